// File: doc/BRIEF.md
# PC Card Bus Access Sequencer

This block turns one request on a simple internal port into a single 8-bit or 16-bit access on a 16-bit PC Card style bus. A request carries an address, write data, a size (byte or word), a direction and a target space. The space is common memory, attribute memory or I/O. The block works out the two card-enable strobes, the register-select line and the kind of strobe from the space, the address parity and the size. It then runs the access through three phases: setup, strobe-active and hold.

Each space has its own programmed length, in clock cycles, for the strobe-active phase. When the stretch feature is enabled, the card can lengthen that phase by holding its active-low wait line low. The wait line passes through a two-flop synchronizer first. The phase therefore ends only when the programmed count has run out and the synchronized wait line is high. For the card's wait to be seen in time, the programmed length must be at least four cycles plus the card's worst wait-assertion delay, in cycles.

Some combinations cannot be issued on the bus. These requests finish at once with an error flag, and the bus stays quiet throughout.

Top module: `pccard_seq`

## Requirements
- R1: After reset, both card enables, register-select and all four strobes are high, `card_doe` and `rsp_ready` are low, and `req_ready` is high.
- R2: A byte access at an even address drives `card_ce1_n` low and `card_ce2_n` high. A byte write drives its low data byte onto both lanes of `card_dout`. A byte read returns `card_din[7:0]` zero-extended.
- R3: A byte access at an odd address in common or I/O space drives `card_ce1_n` high and `card_ce2_n` low. A read returns `card_din[15:8]` zero-extended.
- R4: A word access at an even address drives both card enables low and moves all 16 data bits. A word access at an odd address is rejected.
- R5: Space codes are 0 = common, 1 = attribute, 2 = I/O, 3 = reserved (always rejected). `card_reg_n` is low for attribute and I/O accesses and high for common accesses. Attribute space accepts only byte accesses at even addresses.
- R6: Memory accesses (common or attribute) use `card_oe_n` for reads and `card_we_n` for writes. I/O accesses use `card_iord_n` for reads and `card_iowr_n` for writes. At most one strobe is low at any time, and only while a card enable is low.
- R7: With stretching disabled, the strobe stays low for exactly the programmed cycle count of the space: `cfg_mem_cycles` for common, `cfg_att_cycles` for attribute, `cfg_io_cycles` for I/O. A count of 0 acts as 1.
- R8: With `cfg_wait_en` high, the strobe phase lasts until the programmed count has expired and the synchronized `card_wait_n` is high. Suppose the card pulls wait low on the first strobe cycle and releases it W cycles later, with a count of N. The strobe then stays low for max(N, W+3) cycles.
- R9: With `cfg_wait_en` low, `card_wait_n` has no effect on the strobe length.
- R10: A rejected request raises `rsp_ready` together with `rsp_error` one cycle after acceptance, with no enable, strobe or `card_doe` activity and `rsp_rdata` zero.
- R11: An accepted access has one setup cycle (enables low, no strobe), the strobe phase of L cycles, and one hold cycle (enables low, no strobe). `rsp_ready` is then high for exactly one cycle, L+3 cycles after the accepting edge. `req_ready` stays low from acceptance until after that cycle.
- R12: Read data is sampled from `card_din` on the last strobe cycle. `rsp_rdata` is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_space | input | 2 | 0 common, 1 attribute, 2 I/O, 3 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data (byte in bits 7..0) |
| cfg_wait_en | input | 1 | Enables stretching by the card |
| cfg_mem_cycles | input | CNT_W | Strobe phase length, common space |
| cfg_att_cycles | input | CNT_W | Strobe phase length, attribute space |
| cfg_io_cycles | input | CNT_W | Strobe phase length, I/O space |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Request rejected (valid with `rsp_ready`) |
| rsp_rdata | output | DATA_W | Read data (byte zero-extended) |
| card_ce1_n | output | 1 | Low-byte card enable |
| card_ce2_n | output | 1 | High-byte card enable |
| card_reg_n | output | 1 | Register-select, low for attribute/I/O |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_addr | output | ADDR_W | Card address |
| card_dout | output | DATA_W | Write data to the card |
| card_doe | output | 1 | Write data drive enable |
| card_din | input | DATA_W | Read data from the card |
| card_wait_n | input | 1 | Active-low stretch request from the card |

## Verification
The case hardest to reach from the ports is a stretched strobe phase. Here the release of the card's wait line falls after the programmed count has run out, so the two-cycle synchronizer lag decides the phase length. The bench makes the card model react to the strobe itself. On the first sample where a strobe is low, it drops `card_wait_n`. It releases the line a chosen number of cycles later. The bench then compares the observed strobe length with max(N, W+3). The same release pattern is repeated with stretching disabled, and once with a short pulse that the count hides.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [1:0] {
        SP_COMMON = 2'd0,
        SP_ATTR   = 2'd1,
        SP_IO     = 2'd2,
        SP_RSVD   = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_HOLD,
        ST_DONE
    } state_e;

    // Result of decoding one request
    typedef struct packed {
        logic ce_lo_n;   // low-byte enable level during the access
        logic ce_hi_n;   // high-byte enable level during the access
        logic reg_n;     // register-select level during the access
        logic io;        // use I/O strobes
        logic hi_lane;   // byte travels on bits 15..8
        logic word;      // 16-bit transfer
        logic bad;       // combination not allowed on the bus
    } dec_t;

endpackage

// File: rtl/pcc_decode.sv
module pcc_decode
    import pcc_pkg::*;
(
    input  logic [1:0] space,
    input  logic       addr_lsb,
    input  logic       word,
    output dec_t       dec
);
    space_e sp;

    always_comb begin
        sp          = space_e'(space);
        dec.word    = word;
        dec.io      = (sp == SP_IO);
        dec.hi_lane = !word && addr_lsb;
        dec.ce_lo_n = !(word || !addr_lsb);
        dec.ce_hi_n = !(word || addr_lsb);
        dec.reg_n   = !((sp == SP_ATTR) || (sp == SP_IO));
        dec.bad     = (sp == SP_RSVD)
                    || (word && addr_lsb)
                    || ((sp == SP_ATTR) && (addr_lsb || word));
    end
endmodule

// File: rtl/pcc_sync.sv
module pcc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pccard_seq.sv
module pccard_seq
    import pcc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [1:0]        req_space,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_wait_en,
    input  logic [CNT_W-1:0]  cfg_mem_cycles,
    input  logic [CNT_W-1:0]  cfg_att_cycles,
    input  logic [CNT_W-1:0]  cfg_io_cycles,
    output logic              rsp_ready,
    output logic              rsp_error,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              card_ce1_n,
    output logic              card_ce2_n,
    output logic              card_reg_n,
    output logic              card_oe_n,
    output logic              card_we_n,
    output logic              card_iord_n,
    output logic              card_iowr_n,
    output logic [ADDR_W-1:0] card_addr,
    output logic [DATA_W-1:0] card_dout,
    output logic              card_doe,
    input  logic [DATA_W-1:0] card_din,
    input  logic              card_wait_n
);
    localparam int BYTE_W = DATA_W / 2;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        state_e            st;
        logic [CNT_W-1:0]  cnt;
        dec_t              dec;
        logic              write;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q, d;
    dec_t  req_dec;
    logic  wait_s;
    logic  active, strobe;
    logic [CNT_W-1:0] len;

    pcc_decode i_decode (
        .space    (req_space),
        .addr_lsb (req_addr[0]),
        .word     (req_word),
        .dec      (req_dec)
    );

    pcc_sync #(.STAGES(SYNC_STAGES)) i_wait_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (card_wait_n),
        .dout  (wait_s)
    );

    // Per-space strobe length, zero promoted to one
    always_comb begin
        case (space_e'(req_space))
            SP_ATTR: len = cfg_att_cycles;
            SP_IO:   len = cfg_io_cycles;
            default: len = cfg_mem_cycles;
        endcase
        if (len == '0) len = CNT_ONE;
    end

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.dec   = req_dec;
                    d.write = req_write;
                    d.addr  = req_addr;
                    d.wdata = req_word ? req_wdata
                                       : {req_wdata[BYTE_W-1:0], req_wdata[BYTE_W-1:0]};
                    d.rdata = '0;
                    d.cnt   = len;
                    d.err   = req_dec.bad;
                    d.st    = req_dec.bad ? ST_DONE : ST_SETUP;
                end
            end
            ST_SETUP: d.st = ST_ACCESS;
            ST_ACCESS: begin
                if (q.cnt > CNT_ONE) begin
                    d.cnt = q.cnt - CNT_ONE;
                end else if (cfg_wait_en && !wait_s) begin
                    d.st = ST_ACCESS;
                end else begin
                    d.st = ST_HOLD;
                    if (!q.write) begin
                        if (q.dec.word)         d.rdata = card_din;
                        else if (q.dec.hi_lane) d.rdata = {{BYTE_W{1'b0}}, card_din[DATA_W-1:BYTE_W]};
                        else                    d.rdata = {{BYTE_W{1'b0}}, card_din[BYTE_W-1:0]};
                    end
                end
            end
            ST_HOLD: d.st = ST_DONE;
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign active = (q.st == ST_SETUP) || (q.st == ST_ACCESS) || (q.st == ST_HOLD);
    assign strobe = (q.st == ST_ACCESS);

    assign req_ready   = (q.st == ST_IDLE);
    assign rsp_ready   = (q.st == ST_DONE);
    assign rsp_error   = (q.st == ST_DONE) && q.err;
    assign rsp_rdata   = q.rdata;
    assign card_ce1_n  = active ? q.dec.ce_lo_n : 1'b1;
    assign card_ce2_n  = active ? q.dec.ce_hi_n : 1'b1;
    assign card_reg_n  = active ? q.dec.reg_n   : 1'b1;
    assign card_oe_n   = !(strobe && !q.dec.io && !q.write);
    assign card_we_n   = !(strobe && !q.dec.io &&  q.write);
    assign card_iord_n = !(strobe &&  q.dec.io && !q.write);
    assign card_iowr_n = !(strobe &&  q.dec.io &&  q.write);
    assign card_addr   = q.addr;
    assign card_dout   = q.wdata;
    assign card_doe    = active && q.write;

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!card_oe_n, !card_we_n, !card_iord_n, !card_iowr_n}));

    // R6
    strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n)
        |-> (!card_ce1_n || !card_ce2_n));

    // R10
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_ready && card_ce1_n && card_ce2_n && !card_doe
                       && rsp_rdata == '0));

    // R11
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active || rsp_ready) |-> !req_ready);

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cfg_wait_en && !wait_s) |=> strobe);

    // R9
    nowait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cfg_wait_en && q.cnt <= CNT_ONE) |=> (q.st == ST_HOLD));
endmodule

// File: tb/test_pccard_seq.sv
`timescale 1ns/1ps
module test_pccard_seq;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int NVEC   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [1:0] req_space = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic cfg_wait_en = 1'b0;
    logic [CNT_W-1:0] cfg_mem_cycles = 8'd4, cfg_att_cycles = 8'd5, cfg_io_cycles = 8'd6;
    logic [DATA_W-1:0] card_din = '0;
    logic card_wait_n = 1'b1;
    logic req_ready, rsp_ready, rsp_error;
    logic [DATA_W-1:0] rsp_rdata, card_dout;
    logic card_ce1_n, card_ce2_n, card_reg_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_doe;
    logic [ADDR_W-1:0] card_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pccard_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_pccard_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_word(req_word), .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_wait_en(cfg_wait_en), .cfg_mem_cycles(cfg_mem_cycles),
        .cfg_att_cycles(cfg_att_cycles), .cfg_io_cycles(cfg_io_cycles),
        .rsp_ready(rsp_ready), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .card_ce1_n(card_ce1_n), .card_ce2_n(card_ce2_n), .card_reg_n(card_reg_n),
        .card_oe_n(card_oe_n), .card_we_n(card_we_n), .card_iord_n(card_iord_n),
        .card_iowr_n(card_iowr_n), .card_addr(card_addr), .card_dout(card_dout),
        .card_doe(card_doe), .card_din(card_din), .card_wait_n(card_wait_n)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  sp;
        logic        wr;
        logic        wd;
        logic [11:0] addr;
        logic [15:0] wdata;
        logic [15:0] din;
        logic        err;
        logic        ce1;
        logic        ce2;
        logic        regn;
        logic [15:0] dout;
        logic [15:0] rdata;
    } vec_t;

    // sp wr wd addr wdata din err ce1 ce2 reg dout rdata
    localparam vec_t VECS [NVEC] = '{
        '{2'd0,1'b0,1'b0,12'h010,16'h0000,16'hA1B2,1'b0,1'b0,1'b1,1'b1,16'h0000,16'h00B2},
        '{2'd0,1'b0,1'b0,12'h011,16'h0000,16'hA1B2,1'b0,1'b1,1'b0,1'b1,16'h0000,16'h00A1},
        '{2'd0,1'b1,1'b1,12'h020,16'h1234,16'h0000,1'b0,1'b0,1'b0,1'b1,16'h1234,16'h0000},
        '{2'd0,1'b1,1'b0,12'h023,16'h0056,16'h0000,1'b0,1'b1,1'b0,1'b1,16'h5656,16'h0000},
        '{2'd1,1'b0,1'b0,12'h100,16'h0000,16'h3C5A,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h005A},
        '{2'd1,1'b0,1'b0,12'h101,16'h0000,16'h3C5A,1'b1,1'b1,1'b1,1'b1,16'h0000,16'h0000},
        '{2'd1,1'b0,1'b1,12'h102,16'h0000,16'h3C5A,1'b1,1'b1,1'b1,1'b1,16'h0000,16'h0000},
        '{2'd2,1'b0,1'b0,12'h041,16'h0000,16'h9F80,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h009F},
        '{2'd2,1'b1,1'b1,12'h040,16'hBEEF,16'h0000,1'b0,1'b0,1'b0,1'b0,16'hBEEF,16'h0000},
        '{2'd2,1'b1,1'b0,12'h042,16'h0077,16'h0000,1'b0,1'b0,1'b1,1'b0,16'h7777,16'h0000},
        '{2'd0,1'b0,1'b1,12'h031,16'h0000,16'h5555,1'b1,1'b1,1'b1,1'b1,16'h0000,16'h0000},
        '{2'd3,1'b0,1'b0,12'h000,16'h0000,16'h5555,1'b1,1'b1,1'b1,1'b1,16'h0000,16'h0000}
    };

    // Observations of the last access
    int lat, en_c, oe_c, we_c, rd_c, wr_c, doe_c, busy_bad;
    logic ce1_s, ce2_s, reg_s, err_s, pulse_ok;
    logic [15:0] dout_s, rdata_s;

    task automatic run_access(input logic [1:0] sp, input logic wr, input logic wd,
                              input logic [11:0] addr, input logic [15:0] wdata,
                              input logic [15:0] din, input int wait_w);
        int wcnt;
        logic seen;
        lat = 0; en_c = 0; oe_c = 0; we_c = 0; rd_c = 0; wr_c = 0; doe_c = 0; busy_bad = 0;
        ce1_s = 1; ce2_s = 1; reg_s = 1; err_s = 0; dout_s = 0; rdata_s = 16'hDEAD;
        pulse_ok = 0; wcnt = 0; seen = 0;
        @(negedge clk);
        req_space = sp; req_write = wr; req_word = wd; req_addr = addr;
        req_wdata = wdata; card_din = din; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (lat < 100) begin
            lat++;
            if (req_ready) busy_bad++;
            if (!card_ce1_n || !card_ce2_n) en_c++;
            if (card_doe) doe_c++;
            if (!card_oe_n) oe_c++;
            if (!card_we_n) we_c++;
            if (!card_iord_n) rd_c++;
            if (!card_iowr_n) wr_c++;
            if (!card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n) begin
                ce1_s = card_ce1_n; ce2_s = card_ce2_n; reg_s = card_reg_n; dout_s = card_dout;
                if (!seen) begin
                    seen = 1;
                    if (wait_w > 0) begin
                        card_wait_n = 1'b0;
                        wcnt = wait_w;
                    end
                end else if (wcnt > 0) begin
                    wcnt--;
                    if (wcnt == 0) card_wait_n = 1'b1;
                end
            end else if (wcnt > 0) begin
                wcnt--;
                if (wcnt == 0) card_wait_n = 1'b1;
            end
            if (rsp_ready) begin
                err_s = rsp_error;
                rdata_s = rsp_rdata;
                break;
            end
            @(negedge clk);
        end
        card_wait_n = 1'b1;
        @(negedge clk);
        pulse_ok = !rsp_ready && req_ready;
    endtask

    initial begin
        #(8ns * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(card_ce1_n && card_ce2_n && card_reg_n && card_oe_n && card_we_n
            && card_iord_n && card_iowr_n && !card_doe && !rsp_ready && req_ready,
            "R1 reset outputs", {card_ce1_n, card_ce2_n, card_reg_n, card_oe_n, card_we_n,
            card_iord_n, card_iowr_n, card_doe, rsp_ready, req_ready}, 10'b1111111001);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table, stretching disabled
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            int len;
            v = VECS[i];
            len = (v.sp == 2'd1) ? 5 : (v.sp == 2'd2) ? 6 : 4;
            run_access(v.sp, v.wr, v.wd, v.addr, v.wdata, v.din, 0);
            chk(err_s == v.err, "R10 error flag", err_s, v.err);
            chk(pulse_ok, "R11 ready pulse width", pulse_ok, 1);
            chk(busy_bad == 0, "R11 req_ready low while busy", busy_bad, 0);
            if (v.err) begin
                chk(lat == 1, "R10 reject latency", lat, 1);
                chk(en_c == 0 && doe_c == 0 && (oe_c + we_c + rd_c + wr_c) == 0,
                    "R10 bus quiet on reject", en_c + doe_c + oe_c + we_c + rd_c + wr_c, 0);
                chk(rdata_s == 16'h0, "R10 rdata zero", rdata_s, 0);
            end else begin
                chk(lat == len + 3, "R11 latency", lat, len + 3);
                chk(en_c == len + 2, "R11 setup/hold enables", en_c, len + 2);
                chk({ce1_s, ce2_s} == {v.ce1, v.ce2}, "R2 R3 R4 card enables", {ce1_s, ce2_s}, {v.ce1, v.ce2});
                chk(reg_s == v.regn, "R5 register select", reg_s, v.regn);
                if (v.sp == 2'd2) begin
                    chk(rd_c == (v.wr ? 0 : len) && wr_c == (v.wr ? len : 0) && oe_c == 0 && we_c == 0,
                        "R6 R7 I/O strobe", v.wr ? wr_c : rd_c, len);
                end else begin
                    chk(oe_c == (v.wr ? 0 : len) && we_c == (v.wr ? len : 0) && rd_c == 0 && wr_c == 0,
                        "R6 R7 memory strobe", v.wr ? we_c : oe_c, len);
                end
                if (v.wr) begin
                    chk(dout_s == v.dout, "R2 R4 write data lanes", dout_s, v.dout);
                    chk(doe_c == len + 2, "R11 data drive window", doe_c, len + 2);
                end
                chk(rdata_s == v.rdata, "R12 R3 read data", rdata_s, v.rdata);
            end
        end

        // R7 zero count acts as one
        cfg_mem_cycles = 8'd0;
        run_access(2'd0, 1'b0, 1'b1, 12'h050, 16'h0, 16'hCAFE, 0);
        chk(oe_c == 1, "R7 zero length", oe_c, 1);
        chk(rdata_s == 16'hCAFE, "R12 word read", rdata_s, 16'hCAFE);
        cfg_mem_cycles = 8'd4;

        // R9 wait ignored when disabled
        cfg_wait_en = 1'b0;
        run_access(2'd0, 1'b0, 1'b0, 12'h060, 16'h0, 16'h0011, 6);
        chk(oe_c == 4, "R9 wait ignored", oe_c, 4);
        chk(lat == 7, "R9 latency unchanged", lat, 7);

        // R8 long stretch: max(4, 6+3) = 9
        cfg_wait_en = 1'b1;
        run_access(2'd0, 1'b0, 1'b0, 12'h060, 16'h0, 16'h0022, 6);
        chk(oe_c == 9, "R8 stretched strobe", oe_c, 9);
        chk(lat == 12, "R8 stretched latency", lat, 12);
        chk(rdata_s == 16'h0022, "R8 R12 data after stretch", rdata_s, 16'h0022);

        // R8 I/O write stretch: count 6, W=5 -> 8
        run_access(2'd2, 1'b1, 1'b1, 12'h040, 16'h7E7E, 16'h0, 5);
        chk(wr_c == 8, "R8 I/O stretched strobe", wr_c, 8);

        // R8 short pulse hidden by count: max(4, 1+3) = 4
        run_access(2'd0, 1'b1, 1'b0, 12'h070, 16'h0033, 16'h0, 1);
        chk(we_c == 4, "R8 short wait absorbed", we_c, 4);
        cfg_wait_en = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule